// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

This block takes one asynchronous serial line that idles high and turns each 8N1 frame on it into a parallel byte. A free-running divider makes a sample-enable pulse at sixteen times the line rate from the system clock. A controller counts those pulses. It confirms the start bit at its middle, then samples each data bit one bit period later at that bit's centre.

When the last data bit has been taken, the byte appears on the output with a one-cycle valid strobe. The controller then waits one more bit period, which places it inside the stop bit, before it watches for the next start edge. The clock frequency, line rate, oversampling factor and data width are parameters. The defaults are a 100 MHz clock and 19200 baud.

Top module: `serial_byte_rx`

## Requirements
- R1: During and right after synchronous active-low reset, `valid_o` is 0 and `data_o` is 0x00.
- R2: Sample-enable pulses come every CLK_HZ/(BAUD*16) system cycles, and no two pulses fall in adjacent cycles.
- R3: The line passes through a two-flop synchroniser. A high-to-low transition starts a frame. The controller counts sample pulses from 0 and, on reaching 7 (mid start bit), accepts the start bit if the line is still low.
- R4: After the start bit is accepted, the line is sampled once every 16 sample pulses. The first sample is bit 0 (least significant) of the byte.
- R5: Exactly 8 samples form a byte, and `valid_o` rises in the cycle that follows the eighth sample, about 136 sample pulses after the start edge.
- R6: `valid_o` lasts exactly one cycle, and `data_o` changes only together with a `valid_o` strobe.
- R7: If the line is high at the mid-start sample, the event is a glitch. The block returns to idle and outputs no byte.
- R8: After the byte is output, the block waits 16 sample pulses before idling. A new frame needs a fresh high-to-low transition, so a line held low after a frame yields no second byte.
- R9: Frames sent back to back with a single stop bit are all received, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| data_o | output | 8 | Last received byte, held until the next one |
| valid_o | output | 1 | One-cycle strobe marking a new byte |

## Verification
The assertions assume that the line rate seen on `rx_i` matches the BAUD parameter closely enough for 16 sample pulses to span one bit. They also assume that a start bit lasts longer than the 8-pulse confirmation window unless it is meant as a glitch. The stimulus drives every bit for exactly 16 divider periods, away from the clock edge. Glitches are kept at 3 sample periods, well under the confirmation point. Break conditions hold the line low for many bit times, so that the requirement for a fresh edge is exercised without bending the bit timing.

// File: rtl/serial_rx_pkg.sv
// Shared types for the serial byte receiver.
// Assumes nothing beyond a standard SystemVerilog compiler.
package serial_rx_pkg;

    typedef enum logic [1:0] {
        RXS_IDLE  = 2'd0,
        RXS_START = 2'd1,
        RXS_DATA  = 2'd2,
        RXS_STOP  = 2'd3
    } rx_state_e;

endpackage

// File: rtl/serial_rx_tickgen.sv
// Sample-enable generator: divides the system clock down to OVERSAMPLE
// times the line rate. Assumes CLK_HZ >= BAUD*OVERSAMPLE.
module serial_rx_tickgen #(
    parameter int CLK_HZ     = 100_000_000,
    parameter int BAUD       = 19_200,
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int DIV   = CLK_HZ / (BAUD * OVERSAMPLE);
    localparam int DIV_L = (DIV < 1) ? 1 : DIV;
    localparam int CW    = (DIV_L > 1) ? $clog2(DIV_L) : 1;

    generate
        if (DIV_L > 1) begin : g_div
            logic [CW-1:0] cnt_q;

            // Free-running divider; wraps after DIV_L cycles.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (cnt_q == CW'(DIV_L - 1)) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign tick_o = (cnt_q == CW'(DIV_L - 1));

            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o); // R2
        end else begin : g_nodiv
            assign tick_o = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/serial_rx_sync.sv
// Two-flop synchroniser with a falling-edge detector. Assumes an idle-high
// line; both stages and the edge history reset high.
module serial_rx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    output logic rx_s_o,
    output logic fall_o
);
    logic meta_q, sync_q, hist_q;

    // Bring the asynchronous line into the clock domain and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            hist_q <= 1'b1;
        end else begin
            meta_q <= rx_i;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign rx_s_o = sync_q;
    assign fall_o = hist_q & ~sync_q;

    AST_FALL_IS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o); // R3

endmodule

// File: rtl/serial_rx_ctrl.sv
// Frame controller: confirms the start bit at mid-bit, samples each data
// bit at its centre (LSB first), presents the byte, then waits into the
// stop bit. Assumes a one-cycle sample-enable pulse and a synchronised line.
module serial_rx_ctrl
    import serial_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int DATA_BITS  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 rx_s_i,
    input  logic                 fall_i,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 valid_o
);
    localparam int TW      = $clog2(OVERSAMPLE);
    localparam int BW      = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam int MID     = OVERSAMPLE / 2 - 1;
    localparam int LASTTCK = OVERSAMPLE - 1;
    localparam int LASTBIT = DATA_BITS - 1;

    rx_state_e            state_q;
    logic [TW-1:0]        tcnt_q;
    logic [BW-1:0]        bidx_q;
    logic [DATA_BITS-1:0] shift_q;
    logic [DATA_BITS-1:0] next_shift;

    assign next_shift = {rx_s_i, shift_q[DATA_BITS-1:1]};

    // Sequence through idle, start check, data collection and stop wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RXS_IDLE;
            tcnt_q  <= '0;
            bidx_q  <= '0;
            shift_q <= '0;
            data_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            unique case (state_q)
                RXS_IDLE: begin
                    tcnt_q <= '0;
                    if (fall_i) begin
                        state_q <= RXS_START;
                    end
                end
                RXS_START: begin
                    if (tick_i) begin
                        if (tcnt_q == TW'(MID)) begin
                            tcnt_q <= '0;
                            bidx_q <= '0;
                            state_q <= rx_s_i ? RXS_IDLE : RXS_DATA;
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                end
                RXS_DATA: begin
                    if (tick_i) begin
                        if (tcnt_q == TW'(LASTTCK)) begin
                            tcnt_q  <= '0;
                            shift_q <= next_shift;
                            bidx_q  <= bidx_q + 1'b1;
                            if (bidx_q == BW'(LASTBIT)) begin
                                data_o  <= next_shift;
                                valid_o <= 1'b1;
                                state_q <= RXS_STOP;
                            end
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                end
                RXS_STOP: begin
                    if (tick_i) begin
                        if (tcnt_q == TW'(LASTTCK)) begin
                            tcnt_q  <= '0;
                            state_q <= RXS_IDLE;
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                end
                default: state_q <= RXS_IDLE;
            endcase
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R6
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_o) |-> valid_o); // R6
    AST_VALID_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($past(state_q) == RXS_DATA) && (state_q == RXS_STOP)); // R5
    AST_GLITCH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RXS_START && tick_i && tcnt_q == TW'(MID) && rx_s_i)
        |=> (state_q == RXS_IDLE) && !valid_o); // R7
    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RXS_STOP && tick_i && tcnt_q == TW'(LASTTCK))
        |=> state_q == RXS_IDLE); // R8
    AST_START_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == RXS_IDLE && state_q == RXS_START) |-> $past(fall_i)); // R3

endmodule

// File: rtl/serial_byte_rx.sv
// Top level of the serial byte receiver: tick generator, line synchroniser
// and frame controller. Assumes an 8N1 idle-high line at BAUD.
module serial_byte_rx #(
    parameter int CLK_HZ     = 100_000_000,
    parameter int BAUD       = 19_200,
    parameter int OVERSAMPLE = 16,
    parameter int DATA_BITS  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_i,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 valid_o
);
    logic tick, rx_s, fall;

    serial_rx_tickgen #(
        .CLK_HZ    (CLK_HZ),
        .BAUD      (BAUD),
        .OVERSAMPLE(OVERSAMPLE)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_o(tick)
    );

    serial_rx_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .rx_i  (rx_i),
        .rx_s_o(rx_s),
        .fall_o(fall)
    );

    serial_rx_ctrl #(
        .OVERSAMPLE(OVERSAMPLE),
        .DATA_BITS (DATA_BITS)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .rx_s_i (rx_s),
        .fall_i (fall),
        .data_o (data_o),
        .valid_o(valid_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !valid_o && data_o == '0); // R1

endmodule

// File: tb/tb_serial_byte_rx.sv
// Directed bench for serial_byte_rx: one task per scenario.
module tb_serial_byte_rx;
    localparam int CLK_HZ = 200_000_000;
    localparam int BAUD   = 1_250_000;
    localparam int DIV    = CLK_HZ / (BAUD * 16);
    localparam int BITCLK = DIV * 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic [7:0] data;
    logic       valid;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int got_n = 0;
    logic [7:0] got [0:15];
    int run_len = 0;
    int max_run = 0;
    int data_moves_bad = 0;
    int last_valid_cyc = 0;
    logic [7:0] prev_data = 8'h00;

    always #2.5 clk = ~clk;

    serial_byte_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) dut (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .data_o(data), .valid_o(valid)
    );

    // Record strobes and data motion at the falling edge.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (valid) begin
            if (got_n < 16) got[got_n] = data;
            got_n = got_n + 1;
            run_len = run_len + 1;
            if (run_len > max_run) max_run = run_len;
            if (run_len == 1) last_valid_cyc = cyc;
        end else begin
            run_len = 0;
        end
        if (data !== prev_data && !valid) data_moves_bad = data_moves_bad + 1;
        prev_data = data;
    end

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        total = total + 1;
        bad = bad + 1;
        $display("FAIL watchdog: act=%0d exp=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [7:0] b, input int stop_bits);
        @(negedge clk) rx = 1'b0;
        repeat (BITCLK) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            repeat (BITCLK) @(negedge clk);
        end
        rx = 1'b1;
        repeat (BITCLK * stop_bits) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (5) @(negedge clk);
        check(valid === 1'b0, "R1 valid", valid, 0);
        check(data === 8'h00, "R1 data", data, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(valid === 1'b0, "R1 valid after release", valid, 0);
    endtask

    task automatic t_single(input logic [7:0] b);
        int n0;
        n0 = got_n;
        send_frame(b, 2);
        check(got_n == n0 + 1, "R5 one byte per frame", got_n - n0, 1);
        check(got[n0] == b, "R4 byte value LSB first", got[n0], b);
    endtask

    task automatic t_latency();
        int t0;
        int lat;
        @(negedge clk);
        t0 = cyc;
        send_frame(8'h96, 2);
        lat = last_valid_cyc - t0;
        check(lat >= 136 * DIV && lat <= 136 * DIV + DIV + 6,
              "R2 R3 R5 strobe timing", lat, 136 * DIV);
    endtask

    task automatic t_glitch();
        int n0;
        n0 = got_n;
        @(negedge clk) rx = 1'b0;
        repeat (3 * DIV) @(negedge clk);
        rx = 1'b1;
        repeat (3 * BITCLK) @(negedge clk);
        check(got_n == n0, "R7 glitch yields no byte", got_n - n0, 0);
        t_single(8'h3C);
    endtask

    task automatic t_break();
        int n0;
        n0 = got_n;
        @(negedge clk) rx = 1'b0;
        repeat (BITCLK * 9) @(negedge clk);
        repeat (BITCLK * 20) @(negedge clk);
        rx = 1'b1;
        repeat (BITCLK * 2) @(negedge clk);
        check(got_n == n0 + 1, "R8 held-low line gives one byte", got_n - n0, 1);
        check(got[n0] == 8'h00, "R8 break byte", got[n0], 0);
        t_single(8'hC3);
    endtask

    task automatic t_burst();
        logic [7:0] seq [4];
        int n0;
        seq[0] = 8'h12; seq[1] = 8'hEF; seq[2] = 8'h80; seq[3] = 8'h7E;
        n0 = got_n;
        for (int k = 0; k < 4; k++) send_frame(seq[k], 1);
        repeat (BITCLK) @(negedge clk);
        check(got_n == n0 + 4, "R9 back-to-back count", got_n - n0, 4);
        for (int k = 0; k < 4; k++)
            check(got[n0 + k] == seq[k], "R9 back-to-back order", got[n0 + k], seq[k]);
    endtask

    task automatic t_strobe_shape();
        check(max_run == 1, "R6 valid width", max_run, 1);
        check(data_moves_bad == 0, "R6 data moves only with valid", data_moves_bad, 0);
    endtask

    initial begin
        t_reset();
        repeat (BITCLK) @(negedge clk);
        t_single(8'h55);
        t_single(8'hA5);
        t_single(8'h01);
        t_single(8'h80);
        t_single(8'hFF);
        t_latency();
        t_glitch();
        t_break();
        t_burst();
        t_strobe_shape();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule